// File: doc/BRIEF.md
# Double-Buffered FIR Coefficient Bank Controller

This block sits between a host microcontroller and an FIR filter datapath. The host writes bytes over a byte-wide port. Each byte is tagged as either a command or a data byte. A command byte picks an operation, and the data bytes that follow are applied to it. Some operations load one of a small set of control registers. Others stream coefficients into the idle (shadow) bank or read the live (active) bank back. One operation sets the coefficient address pointer. A read operation returns a status value.

The filter always runs from the active bank, and the host fills the shadow bank in the background. A swap-request bit in the filter control register asks for the two banks to trade roles. The trade does not happen at once. It waits for the filter's end-of-program strobe, and only after the last coefficient (index NCOEF-1) has been written since the previous swap. The trade is a toggle of a bank-select flop, so after a swap the shadow bank holds the previous active set. The request bit clears itself when the swap happens, and a busy output mirrors it.

Top module: `coef_bank_ctrl`

## Requirements
- R1: After a synchronous active-low reset, the filter control register reads 0x0B and every other register is 0x00. Both banks are zero, the pointer is 0, busy is low and host_rdata is 0x00.
- R2: After command 0x30, each data byte is written to the shadow bank at the pointer, and the pointer then advances, wrapping from NCOEF-1 to 0. The active coefficient outputs do not change.
- R3: After command 0x20, host_rdata shows the active-bank coefficient at the pointer in the same cycle. Each host_re pulse advances the pointer, wrapping from NCOEF-1 to 0.
- R4: After command 0x13, each data byte loads the pointer. A value of NCOEF or more loads 0.
- R5: After a load command, each data byte replaces the selected register: 0x14 filter control, 0x12 interrupt mask, 0x10 equalizer settings, 0x11 clock-extraction settings, 0x19 error counter.
- R6: After command 0x22, host_rdata shows the error counter. After command 0x24, it shows speed_in. In idle and in every load mode, host_rdata is 0x00.
- R7: A command byte outside the set 0x10, 0x11, 0x12, 0x13, 0x14, 0x19, 0x20, 0x22, 0x24, 0x30 changes no register, bank or pointer. It ends any stream, and the data bytes and reads that follow have no effect.
- R8: Bit 7 of the filter control register requests a swap. The active and shadow banks trade roles at the first clock edge where all of these hold: prog_end is high, the request bit is set, and the coefficient at index NCOEF-1 has been written since reset or since the last swap. At that edge bit 7 clears. A host write to filter control in the same cycle takes precedence over the clear.
- R9: busy equals bit 7 of the filter control register. It stays high from the swap request until the swap happens.
- R10: A new command byte ends the stream in progress. Data bytes after it go to the new target and leave the banks and pointer alone.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_we | input | 1 | Host byte write strobe |
| host_cmd | input | 1 | 1: byte is a command, 0: byte is data |
| host_wdata | input | 8 | Host byte |
| host_re | input | 1 | Host read strobe (advances the pointer in coefficient read mode) |
| host_rdata | output | 8 | Read data for the current mode, combinational |
| speed_in | input | 8 | Search-speed status value from the datapath |
| prog_end | input | 1 | One-cycle end-of-filter-program strobe |
| active_coefs | output | NCOEF*CW | Active bank, coefficient i at bits [i*CW +: CW] |
| coef_ptr | output | $clog2(NCOEF) | Coefficient pointer |
| fctrl | output | 8 | Filter control register |
| imask | output | 8 | Interrupt mask register |
| eqset | output | 8 | Equalizer settings register |
| clkset | output | 8 | Clock-extraction settings register |
| errcnt | output | 8 | Error counter register |
| busy | output | 1 | Bank swap pending |

## Verification
Every register, bank, pointer and busy change is due on the first clock edge that samples the strobe. That change is visible for the rest of that cycle. host_rdata is combinational, so it shows the new mode, pointer or bank contents in the cycle right after the edge that changed them. A swap shows on active_coefs and busy one edge after the cycle in which prog_end was high. The bench drives inputs just after a rising edge. A behavioural model updates on the same edges, and every output is compared against it at the falling edge, so each result is checked in exactly the cycle it is due.

// File: rtl/coef_bank_pkg.sv
// Shared types for the coefficient bank controller.
// Holds the stream mode encoding, the command byte values and the
// filter control register layout. Assumes 8-bit host bytes.
package coef_bank_pkg;

    typedef enum logic [3:0] {
        MD_IDLE,
        MD_WRCOEF,
        MD_RDCOEF,
        MD_LDPTR,
        MD_LDFCTRL,
        MD_LDIMASK,
        MD_LDEQ,
        MD_LDCLK,
        MD_LDERR,
        MD_RDERR,
        MD_RDSPD
    } mode_t;

    localparam logic [7:0] OP_WRCOEF = 8'h30;
    localparam logic [7:0] OP_RDCOEF = 8'h20;
    localparam logic [7:0] OP_LDPTR  = 8'h13;
    localparam logic [7:0] OP_LDFCTL = 8'h14;
    localparam logic [7:0] OP_LDMASK = 8'h12;
    localparam logic [7:0] OP_LDEQ   = 8'h10;
    localparam logic [7:0] OP_LDCLK  = 8'h11;
    localparam logic [7:0] OP_LDERR  = 8'h19;
    localparam logic [7:0] OP_RDERR  = 8'h22;
    localparam logic [7:0] OP_RDSPD  = 8'h24;

    localparam int          SWAP_BIT  = 7;
    localparam logic [7:0]  FCTRL_RST = 8'h0B;

endpackage

// File: rtl/coef_cmd_decode.sv
// Command byte decoder.
// Maps a host command byte to the stream mode it opens. Unknown bytes
// map to idle and drop the known flag. Purely combinational.
module coef_cmd_decode
    import coef_bank_pkg::*;
(
    input  logic [7:0] cmd_byte,
    output mode_t      cmd_mode,
    output logic       cmd_known
);

    // Translate the byte into a mode.
    always_comb begin
        cmd_known = 1'b1;
        case (cmd_byte)
            OP_WRCOEF: cmd_mode = MD_WRCOEF;
            OP_RDCOEF: cmd_mode = MD_RDCOEF;
            OP_LDPTR:  cmd_mode = MD_LDPTR;
            OP_LDFCTL: cmd_mode = MD_LDFCTRL;
            OP_LDMASK: cmd_mode = MD_LDIMASK;
            OP_LDEQ:   cmd_mode = MD_LDEQ;
            OP_LDCLK:  cmd_mode = MD_LDCLK;
            OP_LDERR:  cmd_mode = MD_LDERR;
            OP_RDERR:  cmd_mode = MD_RDERR;
            OP_RDSPD:  cmd_mode = MD_RDSPD;
            default: begin
                cmd_mode  = MD_IDLE;
                cmd_known = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/coef_ptr_ctr.sv
// Coefficient address pointer.
// A load sets the pointer from a host byte, and out-of-range values
// give 0. A step advances it modulo N. Load wins over step.
// Assumes the caller never asserts both load and step in the same cycle.
module coef_ptr_ctr #(
    parameter int N  = 10,
    parameter int PW = $clog2(N)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [7:0]    load_val,
    input  logic          step,
    output logic [PW-1:0] ptr
);

    localparam logic [PW-1:0] LAST = PW'(N - 1);

    // Pointer register with load and wrapping increment.
    always_ff @(posedge clk) begin
        if (!rst_n)
            ptr <= '0;
        else if (load)
            ptr <= (32'(load_val) < N) ? PW'(load_val) : '0;
        else if (step)
            ptr <= (ptr == LAST) ? '0 : ptr + 1'b1;
    end

    // R2
    ptr_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !load && ptr == LAST) |=> (ptr == '0));

    // R4
    ptr_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (32'(ptr) < N));

endmodule

// File: rtl/coef_bank_pair.sv
// Two coefficient banks with a bank-select flop.
// Writes always go to the bank that is not selected (shadow). The
// selected bank drives the active outputs and the read port. A swap
// toggles the select, so the two banks trade roles with no data copy.
module coef_bank_pair #(
    parameter int N  = 10,
    parameter int W  = 8,
    parameter int PW = $clog2(N)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           wr_en,
    input  logic [PW-1:0]  wr_idx,
    input  logic [W-1:0]   wr_data,
    input  logic           swap,
    input  logic [PW-1:0]  rd_idx,
    output logic [W-1:0]   rd_data,
    output logic [N*W-1:0] active_flat
);

    logic           sel_q;
    logic [W-1:0]   bank_a [N];
    logic [W-1:0]   bank_b [N];

    // Bank select: toggles on each granted swap.
    always_ff @(posedge clk) begin
        if (!rst_n)
            sel_q <= 1'b0;
        else if (swap)
            sel_q <= ~sel_q;
    end

    for (genvar i = 0; i < N; i++) begin : g_cell
        // One coefficient cell in each bank, written only when shadow.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                bank_a[i] <= '0;
                bank_b[i] <= '0;
            end else if (wr_en && wr_idx == PW'(i)) begin
                if (sel_q)
                    bank_a[i] <= wr_data;
                else
                    bank_b[i] <= wr_data;
            end
        end
        assign active_flat[i*W +: W] = sel_q ? bank_b[i] : bank_a[i];
    end

    // Read port on the active bank.
    always_comb begin
        rd_data = '0;
        for (int k = 0; k < N; k++)
            if (rd_idx == PW'(k))
                rd_data = sel_q ? bank_b[k] : bank_a[k];
    end

    // R8
    swap_toggle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        swap |=> (sel_q != $past(sel_q)));

    // R8
    sel_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !swap |=> $stable(sel_q));

    // R2
    active_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !swap |=> $stable(active_flat));

endmodule

// File: rtl/coef_swap_ctl.sv
// Swap arbiter.
// Remembers whether the last coefficient has been written since the
// last swap. Grants a swap on the end-of-program strobe only when the
// host request is set and that coefficient is complete.
module coef_swap_ctl (
    input  logic clk,
    input  logic rst_n,
    input  logic req,
    input  logic prog_end,
    input  logic last_wr,
    output logic fire
);

    logic last_done_q;

    assign fire = req && prog_end && last_done_q;

    // Last-coefficient flag: set by its write, cleared by a swap.
    always_ff @(posedge clk) begin
        if (!rst_n)
            last_done_q <= 1'b0;
        else if (last_wr)
            last_done_q <= 1'b1;
        else if (fire)
            last_done_q <= 1'b0;
    end

    // R8
    no_fire_after_swap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && !last_wr) |=> !fire);

endmodule

// File: rtl/coef_bank_ctrl.sv
// Double-buffered FIR coefficient bank controller (top).
// Decodes host command bytes into a stream mode and applies the data
// bytes and reads that follow. Holds the control registers, the
// coefficient pointer and the two banks, and grants bank swaps at a
// safe filter boundary. Assumes one host byte at most per cycle.
module coef_bank_ctrl
    import coef_bank_pkg::*;
#(
    parameter int NCOEF = 10,
    parameter int CW    = 8,
    parameter int PW    = $clog2(NCOEF)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               host_we,
    input  logic               host_cmd,
    input  logic [7:0]         host_wdata,
    input  logic               host_re,
    output logic [7:0]         host_rdata,
    input  logic [7:0]         speed_in,
    input  logic               prog_end,
    output logic [NCOEF*CW-1:0] active_coefs,
    output logic [PW-1:0]      coef_ptr,
    output logic [7:0]         fctrl,
    output logic [7:0]         imask,
    output logic [7:0]         eqset,
    output logic [7:0]         clkset,
    output logic [7:0]         errcnt,
    output logic               busy
);

    localparam logic [PW-1:0] LAST_IDX = PW'(NCOEF - 1);

    mode_t          mode_q;
    mode_t          dec_mode;
    logic           dec_known;
    logic           cmd_stb, dat_stb, rd_stb;
    logic           coef_wr, last_wr, ptr_load, ptr_step;
    logic           swap_fire;
    logic           fctrl_wr;
    logic [CW-1:0]  coef_rd;

    assign cmd_stb  = host_we && host_cmd;
    assign dat_stb  = host_we && !host_cmd;
    assign rd_stb   = host_re && !cmd_stb;
    assign coef_wr  = dat_stb && (mode_q == MD_WRCOEF);
    assign last_wr  = coef_wr && (coef_ptr == LAST_IDX);
    assign ptr_load = dat_stb && (mode_q == MD_LDPTR);
    assign ptr_step = coef_wr || (rd_stb && mode_q == MD_RDCOEF);
    assign fctrl_wr = dat_stb && (mode_q == MD_LDFCTRL);
    assign busy     = fctrl[SWAP_BIT];

    coef_cmd_decode u_dec (
        .cmd_byte  (host_wdata),
        .cmd_mode  (dec_mode),
        .cmd_known (dec_known)
    );

    coef_ptr_ctr #(.N(NCOEF), .PW(PW)) u_ptr (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (ptr_load),
        .load_val (host_wdata),
        .step     (ptr_step),
        .ptr      (coef_ptr)
    );

    coef_bank_pair #(.N(NCOEF), .W(CW), .PW(PW)) u_banks (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en       (coef_wr),
        .wr_idx      (coef_ptr),
        .wr_data     (host_wdata[CW-1:0]),
        .swap        (swap_fire),
        .rd_idx      (coef_ptr),
        .rd_data     (coef_rd),
        .active_flat (active_coefs)
    );

    coef_swap_ctl u_swap (
        .clk      (clk),
        .rst_n    (rst_n),
        .req      (fctrl[SWAP_BIT]),
        .prog_end (prog_end),
        .last_wr  (last_wr),
        .fire     (swap_fire)
    );

    // Stream mode: every command byte opens a new mode (idle if unknown).
    always_ff @(posedge clk) begin
        if (!rst_n)
            mode_q <= MD_IDLE;
        else if (cmd_stb)
            mode_q <= dec_mode;
    end

    // Filter control: host write wins over the self-clear of the swap bit.
    always_ff @(posedge clk) begin
        if (!rst_n)
            fctrl <= FCTRL_RST;
        else if (fctrl_wr)
            fctrl <= host_wdata;
        else if (swap_fire)
            fctrl[SWAP_BIT] <= 1'b0;
    end

    // Plain load registers written by their data bytes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            imask  <= '0;
            eqset  <= '0;
            clkset <= '0;
            errcnt <= '0;
        end else if (dat_stb) begin
            case (mode_q)
                MD_LDIMASK: imask  <= host_wdata;
                MD_LDEQ:    eqset  <= host_wdata;
                MD_LDCLK:   clkset <= host_wdata;
                MD_LDERR:   errcnt <= host_wdata;
                default: ;
            endcase
        end
    end

    // Read mux: only read modes return data, all others give zero.
    always_comb begin
        case (mode_q)
            MD_RDCOEF: host_rdata = 8'(coef_rd);
            MD_RDERR:  host_rdata = errcnt;
            MD_RDSPD:  host_rdata = speed_in;
            default:   host_rdata = 8'h00;
        endcase
    end

    // R7
    unknown_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_stb && !dec_known) |=> ($stable(fctrl) || $past(swap_fire))
            && $stable(imask) && $stable(eqset) && $stable(clkset)
            && $stable(errcnt) && $stable(coef_ptr));

    // R9
    busy_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> $past(swap_fire || fctrl_wr));

    // R10
    cmd_no_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_stb |=> $stable(coef_ptr));

endmodule

// File: tb/tb_coef_bank_ctrl.sv
// Bench for coef_bank_ctrl: a behavioural model updated on every edge,
// with all outputs compared to it at every falling edge.
`timescale 1ns/1ps
module tb_coef_bank_ctrl;

    localparam int N = 10;
    localparam int W = 8;
    localparam int P = 4;

    // model mode codes (bench-local)
    localparam int K_IDLE = 0, K_WR = 1, K_RD = 2, K_PTR = 3, K_FCT = 4,
                   K_MSK = 5, K_EQ = 6, K_CLK = 7, K_ERR = 8, K_RERR = 9, K_RSPD = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic host_we = 1'b0, host_cmd = 1'b0, host_re = 1'b0, prog_end = 1'b0;
    logic [7:0] host_wdata = 8'h00, speed_in = 8'h00;
    logic [7:0] host_rdata, fctrl, imask, eqset, clkset, errcnt;
    logic [N*W-1:0] active_coefs;
    logic [P-1:0] coef_ptr;
    logic busy;

    int checks = 0;
    int fails  = 0;
    string tag = "R1";
    bit done = 0;

    // model state
    int m_bank [2][N];
    int m_sel, m_ptr, m_mode, m_last;
    int m_fctrl, m_imask, m_eq, m_clk, m_err;

    always #2.5 clk = ~clk;

    coef_bank_ctrl dut (
        .clk(clk), .rst_n(rst_n), .host_we(host_we), .host_cmd(host_cmd),
        .host_wdata(host_wdata), .host_re(host_re), .host_rdata(host_rdata),
        .speed_in(speed_in), .prog_end(prog_end), .active_coefs(active_coefs),
        .coef_ptr(coef_ptr), .fctrl(fctrl), .imask(imask), .eqset(eqset),
        .clkset(clkset), .errcnt(errcnt), .busy(busy)
    );

    function automatic int cmd_to_mode(int b);
        case (b)
            'h30: return K_WR;   'h20: return K_RD;   'h13: return K_PTR;
            'h14: return K_FCT;  'h12: return K_MSK;  'h10: return K_EQ;
            'h11: return K_CLK;  'h19: return K_ERR;  'h22: return K_RERR;
            'h24: return K_RSPD; default: return K_IDLE;
        endcase
    endfunction

    function automatic int exp_rdata();
        if (m_mode == K_RD)   return m_bank[m_sel][m_ptr];
        if (m_mode == K_RERR) return m_err;
        if (m_mode == K_RSPD) return int'(speed_in);
        return 0;
    endfunction

    // reference model, one step per rising edge
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int b = 0; b < 2; b++) for (int i = 0; i < N; i++) m_bank[b][i] = 0;
            m_sel = 0; m_ptr = 0; m_mode = K_IDLE; m_last = 0;
            m_fctrl = 'h0B; m_imask = 0; m_eq = 0; m_clk = 0; m_err = 0;
        end else begin
            bit fire, lw, fw;
            fire = prog_end && m_fctrl[7] && (m_last != 0);
            lw = 0; fw = 0;
            if (host_we && host_cmd) begin
                m_mode = cmd_to_mode(int'(host_wdata));
            end else begin
                if (host_we) begin
                    case (m_mode)
                        K_WR: begin
                            m_bank[1 - m_sel][m_ptr] = int'(host_wdata);
                            if (m_ptr == N - 1) lw = 1;
                            m_ptr = (m_ptr + 1) % N;
                        end
                        K_PTR: m_ptr = (int'(host_wdata) < N) ? int'(host_wdata) : 0;
                        K_FCT: fw = 1;
                        K_MSK: m_imask = int'(host_wdata);
                        K_EQ:  m_eq    = int'(host_wdata);
                        K_CLK: m_clk   = int'(host_wdata);
                        K_ERR: m_err   = int'(host_wdata);
                        default: ;
                    endcase
                end
                if (host_re && m_mode == K_RD) m_ptr = (m_ptr + 1) % N;
            end
            if (fw) m_fctrl = int'(host_wdata);
            else if (fire) m_fctrl = m_fctrl & 'h7F;
            if (lw) m_last = 1;
            else if (fire) m_last = 0;
            if (fire) m_sel = 1 - m_sel;
        end
    end

    task automatic chk(string what, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    // compare every output at the falling edge
    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk("host_rdata", int'(host_rdata), exp_rdata());
            chk("coef_ptr", int'(coef_ptr), m_ptr);
            chk("fctrl", int'(fctrl), m_fctrl);
            chk("imask", int'(imask), m_imask);
            chk("eqset", int'(eqset), m_eq);
            chk("clkset", int'(clkset), m_clk);
            chk("errcnt", int'(errcnt), m_err);
            chk("busy", int'(busy), (m_fctrl >> 7) & 1);
            for (int i = 0; i < N; i++)
                chk($sformatf("active[%0d]", i), int'(active_coefs[i*W +: W]), m_bank[m_sel][i]);
        end
    end

    task automatic step1();
        @(posedge clk); #1;
        host_we = 0; host_cmd = 0; host_re = 0; prog_end = 0;
    endtask

    task automatic cmd(input logic [7:0] b);
        host_we = 1; host_cmd = 1; host_wdata = b; step1();
    endtask

    task automatic dat(input logic [7:0] b);
        host_we = 1; host_cmd = 0; host_wdata = b; step1();
    endtask

    task automatic rd();
        host_re = 1; step1();
    endtask

    task automatic pend();
        prog_end = 1; step1();
    endtask

    task automatic finish_run();
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    initial begin
        #(200000 * 5);
        checks++; fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1;
        tag = "R1"; step1(); step1();

        tag = "R4";
        cmd(8'h13); dat(8'd7); dat(8'd12); dat(8'd3);

        tag = "R2";
        cmd(8'h30);
        for (int i = 0; i < N; i++) dat(8'(i * 13 + 5));
        dat(8'h5A);

        tag = "R3";
        cmd(8'h13); dat(8'd0);
        cmd(8'h20);
        for (int i = 0; i < 12; i++) rd();

        tag = "R8";
        pend();
        cmd(8'h14); dat(8'h8B);
        tag = "R9"; step1(); step1();
        tag = "R8"; pend(); step1();
        tag = "R3";
        cmd(8'h20);
        for (int i = 0; i < N; i++) rd();

        tag = "R8";
        cmd(8'h14); dat(8'h80);
        pend(); pend();
        cmd(8'h13); dat(8'd9);
        cmd(8'h30); dat(8'hAA);
        step1(); pend(); step1();
        cmd(8'h20); rd(); rd();

        tag = "R5";
        cmd(8'h12); dat(8'h55);
        cmd(8'h10); dat(8'h66);
        cmd(8'h11); dat(8'h77);
        cmd(8'h19); dat(8'h88); dat(8'h89);
        cmd(8'h14); dat(8'h2C);

        tag = "R6";
        cmd(8'h22); rd();
        speed_in = 8'h3C;
        cmd(8'h24); rd(); speed_in = 8'hC3; step1();
        cmd(8'h12); rd(); step1();

        tag = "R7";
        cmd(8'h30); dat(8'h01);
        cmd(8'hFF); dat(8'h12); rd(); dat(8'h34);
        cmd(8'h21); dat(8'h99); step1();

        tag = "R10";
        cmd(8'h30); dat(8'h42);
        cmd(8'h14); dat(8'h0B); dat(8'h0C);
        cmd(8'h20); rd();
        cmd(8'h13); dat(8'd5); step1();

        step1();
        finish_run();
    end

endmodule